// File: doc/BRIEF.md
# SPI Register Bank with Status Summary

This block is the host-facing register file of a supervisory device. A host talks to it as an SPI slave using 16-bit frames. The low byte of each frame carries a 7-bit register address and an access-type bit. The high byte carries write data toward the device, or returns register contents toward the host.

Two kinds of register sit behind the port:

- **Status registers** hold sticky event flags. On-chip logic raises these flags through per-bit set inputs. The host clears them with a read-and-clear access.
- **Control registers** are written by the host, or read back without change.

Every response also carries a summary byte in its first eight bit times. The summary has one bit per summarised status register. Because of this, the host only needs to read the status registers whose summary bit is set.

The SPI pins are oversampled by the system clock, so all state lives in one clock domain. Events, the wake-level byte and the mode-block input are synchronous to that clock. A mode-block input (high while the device is in a restart, sleep or fail-safe mode) makes the block ignore SPI frames completely.

Top module: `spi_status_regbank`

## Requirements
- R1: Frame bit 0 is shifted first. Bits 6..0 are the address, bit 7 is the access bit, and bits 15..8 are data. SDI is sampled on rising SCLK, and SDO changes only after falling SCLK.
- R2: SDO frame bits 7..0 carry the summary byte captured when CSN falls. SDO bits 15..8 carry the addressed register contents as they are after the 8th SCLK edge of the same frame.
- R3: Status flags stay set until a committed read-and-clear (access bit 1) of their register. A read-only status access (access bit 0) leaves them unchanged.
- R4: A read-and-clear clears only the bits reported in that frame. A bit whose set input is high in the commit cycle stays set, so events arriving during the frame survive.
- R5: Control registers sit at addresses 0x01..0x04 and reset to 0. A write (access bit 1) returns the old value and takes effect when CSN rises, so it is visible from the next frame on. Access bit 0 only reads.
- R6: Summary bits 0..7 belong to status addresses 0x41, 0x42, 0x43, 0x44, 0x45, 0x46, 0x47 and 0x4C, in that order. A summary bit is 1 exactly when its register is nonzero.
- R7: Address 0x48 returns the live wake-level byte. It has no summary bit, and a read-and-clear of it changes nothing.
- R8: While `blocked_i` is high at CSN rise, the frame has no effect. No write takes place, no clear takes place, and no fail flag is set.
- R9: A frame is committed only if exactly 16 SCLK rising edges were seen. Any other count discards the frame and sets bit 0 of status register 0x43.
- R10: An unimplemented address returns data 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| blocked_i | input | 1 | High while SPI access is blocked by device mode |
| csn_i | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI clock, idle low |
| sdi_i | input | 1 | SPI serial data in |
| sdo_o | output | 1 | SPI serial data out |
| evt_i | input | 64 | Per-bit set strobes; byte k feeds summarised status register k |
| wk_lvl_i | input | 8 | Live wake-level byte, read at 0x48 |

## Verification
The assertions check three things on every cycle:

- A status flag never falls without a clear.
- A set strobe always lands in its flag on the following cycle.
- Control registers hold still except after a committed, unblocked frame.

Only the bench scenarios can show the rest:

- The frame layout on SDO.
- The old-value return on a control write.
- Read-and-clear masking when an event arrives mid-frame.
- The summary mapping, including 0x4C and the excluded wake-level register.
- Fail flagging for short and long frames.
- The zero return for unimplemented addresses.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int FRAME_W  = 16;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 7;
  localparam int N_STAT   = 8;
  localparam logic [ADDR_W-1:0] WK_LVL_ADDR = 7'h48;
  localparam int FAIL_REG = 2;
  localparam int FAIL_BIT = 0;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_STAT,
    KIND_WKLVL,
    KIND_CTRL
  } reg_kind_e;

  // summary order is behaviour: 0x41..0x47 then 0x4C
  function automatic logic [ADDR_W-1:0] stat_addr(input int idx);
    return (idx < 7) ? ADDR_W'(32'h41 + idx) : 7'h4C;
  endfunction
endpackage

// File: rtl/spi_rb_frontend.sv
module spi_rb_frontend #(
  parameter int FW = 16,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          csn_i,
  input  logic          sclk_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  input  logic [BW-1:0] summary_i,
  input  logic [BW-1:0] rdata_i,
  output logic          hdr_valid_o,
  output logic [FW-1:0] frame_o,
  output logic          frame_end_o,
  output logic          frame_good_o
);
  localparam int CNT_W = $clog2(FW + 2);
  localparam int IDX_W = $clog2(FW);

  logic [1:0] csn_s, sclk_s, sdi_s;
  logic csn_d, sclk_d;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [FW-1:0] rx_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_s  <= 2'b11;
      sclk_s <= 2'b00;
      sdi_s  <= 2'b00;
      csn_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      csn_s  <= {csn_s[0], csn_i};
      sclk_s <= {sclk_s[0], sclk_i};
      sdi_s  <= {sdi_s[0], sdi_i};
      csn_d  <= csn_s[1];
      sclk_d <= sclk_s[1];
    end
  end

  logic active, csn_fall, csn_rise, sclk_rise, sclk_fall;
  assign active    = ~csn_s[1];
  assign csn_fall  = csn_d & ~csn_s[1];
  assign csn_rise  = ~csn_d & csn_s[1];
  assign sclk_rise = active & ~sclk_d & sclk_s[1];
  assign sclk_fall = active & sclk_d & ~sclk_s[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      idx_q        <= '0;
      rx_q         <= '0;
      tx_q         <= '0;
      hdr_valid_o  <= 1'b0;
      frame_end_o  <= 1'b0;
      frame_good_o <= 1'b0;
    end else begin
      hdr_valid_o  <= sclk_rise && (cnt_q == CNT_W'(BW - 1));
      frame_end_o  <= csn_rise;
      frame_good_o <= csn_rise && (cnt_q == CNT_W'(FW));
      if (csn_fall) begin
        cnt_q <= '0;
        idx_q <= '0;
        tx_q  <= {{(FW-BW){1'b0}}, summary_i};
      end else begin
        if (sclk_rise) begin
          rx_q <= {sdi_s[1], rx_q[FW-1:1]};
          if (cnt_q != CNT_W'(FW + 1)) cnt_q <= cnt_q + 1'b1;
        end
        if (sclk_fall && idx_q != IDX_W'(FW - 1)) idx_q <= idx_q + 1'b1;
        if (hdr_valid_o) tx_q[FW-1:BW] <= rdata_i;
      end
    end
  end

  assign sdo_o   = tx_q[idx_q];
  assign frame_o = rx_q;
endmodule

// File: rtl/spi_rb_stat_bank.sv
module spi_rb_stat_bank #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N*W-1:0] set_i,
  input  logic           clr_en_i,
  input  logic [IW-1:0]  clr_idx_i,
  input  logic [W-1:0]   clr_mask_i,
  output logic [N*W-1:0] stat_o,
  output logic [N-1:0]   summary_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] q;
    logic [W-1:0] clr;
    assign clr = (clr_en_i && clr_idx_i == IW'(g)) ? clr_mask_i : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= (q & ~clr) | set_i[g*W +: W];  // set beats clear
    end
    assign stat_o[g*W +: W] = q;
    assign summary_o[g]     = |q;
  end
endmodule

// File: rtl/spi_rb_ctrl_bank.sv
module spi_rb_ctrl_bank #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [IW-1:0]  wr_idx_i,
  input  logic [W-1:0]   wr_data_i,
  output logic [N*W-1:0] ctrl_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))      q <= wr_data_i;
    end
    assign ctrl_o[g*W +: W] = q;
  end
endmodule

// File: rtl/spi_status_regbank.sv
module spi_status_regbank
  import spi_rb_pkg::*;
#(
  parameter int                N_CTRL    = 4,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 7'h01
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     blocked_i,
  input  logic                     csn_i,
  input  logic                     sclk_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  input  logic [N_STAT*BYTE_W-1:0] evt_i,
  input  logic [BYTE_W-1:0]        wk_lvl_i
);
  localparam int SW  = N_STAT * BYTE_W;
  localparam int CW  = N_CTRL * BYTE_W;
  localparam int SIW = $clog2(N_STAT);
  localparam int CIW = (N_CTRL > 1) ? $clog2(N_CTRL) : 1;

  logic              hdr_valid, frame_end, frame_good;
  logic [FRAME_W-1:0] frame;
  logic [BYTE_W-1:0] summary, rdata, snap_q;
  logic [SW-1:0]     stat_q, set_v;
  logic [CW-1:0]     ctrl_q;
  reg_kind_e         kind_d, kind_q;
  logic [SIW-1:0]    sidx_d, sidx_q;
  logic [CIW-1:0]    cidx_d, cidx_q;
  logic [ADDR_W-1:0] hdr_addr;
  logic              commit, acc, clr_any, wr_en, bad_frame;

  spi_rb_frontend #(.FW(FRAME_W), .BW(BYTE_W)) u_fe (
    .clk_i, .rst_ni, .csn_i, .sclk_i, .sdi_i, .sdo_o,
    .summary_i   (summary),
    .rdata_i     (rdata),
    .hdr_valid_o (hdr_valid),
    .frame_o     (frame),
    .frame_end_o (frame_end),
    .frame_good_o(frame_good)
  );

  // after 8 shifts the header byte sits in the upper half
  assign hdr_addr = frame[FRAME_W-2:BYTE_W];

  always_comb begin
    kind_d = KIND_NONE;
    sidx_d = '0;
    cidx_d = '0;
    rdata  = '0;
    for (int i = 0; i < N_STAT; i++) begin
      if (hdr_addr == stat_addr(i)) begin
        kind_d = KIND_STAT;
        sidx_d = SIW'(i);
        rdata  = stat_q[i*BYTE_W +: BYTE_W];
      end
    end
    if (hdr_addr == WK_LVL_ADDR) begin
      kind_d = KIND_WKLVL;
      rdata  = wk_lvl_i;
    end
    for (int i = 0; i < N_CTRL; i++) begin
      if (hdr_addr == ADDR_W'(int'(CTRL_BASE) + i)) begin
        kind_d = KIND_CTRL;
        cidx_d = CIW'(i);
        rdata  = ctrl_q[i*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= KIND_NONE;
      sidx_q <= '0;
      cidx_q <= '0;
      snap_q <= '0;
    end else if (hdr_valid) begin
      kind_q <= kind_d;
      sidx_q <= sidx_d;
      cidx_q <= cidx_d;
      snap_q <= rdata;
    end
  end

  assign acc       = frame[BYTE_W-1];
  assign commit    = frame_end & frame_good & ~blocked_i;
  assign bad_frame = frame_end & ~frame_good & ~blocked_i;
  assign clr_any   = commit & acc & (kind_q == KIND_STAT);
  assign wr_en     = commit & acc & (kind_q == KIND_CTRL);

  always_comb begin
    set_v = evt_i;
    set_v[FAIL_REG*BYTE_W + FAIL_BIT] = evt_i[FAIL_REG*BYTE_W + FAIL_BIT] | bad_frame;
  end

  spi_rb_stat_bank #(.N(N_STAT), .W(BYTE_W)) u_stat (
    .clk_i, .rst_ni,
    .set_i     (set_v),
    .clr_en_i  (clr_any),
    .clr_idx_i (sidx_q),
    .clr_mask_i(snap_q),
    .stat_o    (stat_q),
    .summary_o (summary)
  );

  spi_rb_ctrl_bank #(.N(N_CTRL), .W(BYTE_W)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_en_i  (wr_en),
    .wr_idx_i (cidx_q),
    .wr_data_i(frame[FRAME_W-1:BYTE_W]),
    .ctrl_o   (ctrl_q)
  );
endmodule

// File: rtl/spi_status_regbank_chk.sv
module spi_status_regbank_chk #(
  parameter int SW = 64,
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          blocked_i,
  input logic          frame_end,
  input logic          commit,
  input logic          clr_any,
  input logic [SW-1:0] set_v,
  input logic [SW-1:0] stat_q,
  input logic [CW-1:0] ctrl_q
);
  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_any |=> ((stat_q & $past(stat_q)) == $past(stat_q)));  // R3

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> ((stat_q & $past(set_v)) == $past(set_v)));  // R4

  AST_CTRL_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(ctrl_q));  // R5

  AST_BLOCKED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && blocked_i) |=> $stable(ctrl_q));  // R8

  AST_BLOCKED_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end && blocked_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));  // R8
endmodule

bind spi_status_regbank spi_status_regbank_chk #(.SW(SW), .CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .blocked_i(blocked_i),
  .frame_end(frame_end),
  .commit   (commit),
  .clr_any  (clr_any),
  .set_v    (set_v),
  .stat_q   (stat_q),
  .ctrl_q   (ctrl_q)
);

// File: tb/tb_spi_status_regbank.sv
module tb_spi_status_regbank;
  localparam int HP = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, blocked = 1'b0, csn = 1'b1, sclk = 1'b0, sdi = 1'b0, sdo;
  logic [63:0] evt = '0;
  logic [7:0]  wk = '0;

  spi_status_regbank dut (
    .clk_i(clk), .rst_ni(rst_n), .blocked_i(blocked), .csn_i(csn),
    .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .evt_i(evt), .wk_lvl_i(wk)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0] stat_m [8];
  logic [7:0] ctrl_m [4];

  function automatic int stat_ix(input logic [6:0] a);
    for (int i = 0; i < 7; i++) if (a == 7'(8'h41 + i)) return i;
    if (a == 7'h4C) return 7;
    return -1;
  endfunction

  function automatic int ctrl_ix(input logic [6:0] a);
    if (a >= 7'h01 && a <= 7'h04) return int'(a) - 1;
    return -1;
  endfunction

  function automatic logic [7:0] summ();
    logic [7:0] s;
    for (int i = 0; i < 8; i++) s[i] = |stat_m[i];
    return s;
  endfunction

  function automatic logic [7:0] model_rd(input logic [6:0] a);
    if (stat_ix(a) >= 0) return stat_m[stat_ix(a)];
    if (ctrl_ix(a) >= 0) return ctrl_m[ctrl_ix(a)];
    if (a == 7'h48) return wk;
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse_evt(input logic [63:0] v);
    @(negedge clk) evt = v;
    @(negedge clk) evt = '0;
    for (int i = 0; i < 8; i++) stat_m[i] |= v[i*8 +: 8];
  endtask

  task automatic xfer(input logic [15:0] f, input int nbits, input logic [63:0] mid,
                      output logic [15:0] r);
    r = '0;
    @(negedge clk) csn = 1'b0;
    repeat (HP) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      sdi = f[b % 16];
      repeat (HP) @(negedge clk);
      if (b < 16) r[b] = sdo;
      sclk = 1'b1;
      if (b == 12 && mid != '0) begin
        evt = mid;
        @(negedge clk) evt = '0;
        repeat (HP - 1) @(negedge clk);
      end else begin
        repeat (HP) @(negedge clk);
      end
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // full 16-bit frame with model-predicted response and model update
  task automatic frame_chk(input string tag, input logic [6:0] a, input logic acc,
                           input logic [7:0] d);
    logic [15:0] r, exp;
    exp = {model_rd(a), summ()};
    xfer({d, acc, a}, 16, '0, r);
    check(tag, r, exp);
    if (!blocked && acc) begin
      if (stat_ix(a) >= 0) stat_m[stat_ix(a)] = '0;
      if (ctrl_ix(a) >= 0) ctrl_m[ctrl_ix(a)] = d;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) stat_m[i] = '0;
    for (int i = 0; i < 4; i++) ctrl_m[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state and frame layout
    frame_chk("R1 reset ctrl read", 7'h01, 1'b0, 8'hFF);
    check("R1 sdo idle", {15'b0, sdo}, 16'h0);

    // R6 summary and R3 read-only keeps flags
    pulse_evt(64'h08);
    frame_chk("R6 summary bit0", 7'h41, 1'b0, 8'h00);
    frame_chk("R3 read-only keeps", 7'h41, 1'b0, 8'h00);
    pulse_evt(64'h01 << 56);
    frame_chk("R6 0x4C summary bit7", 7'h4C, 1'b0, 8'h00);

    // R5 write returns old value, visible next frame
    frame_chk("R5 write old value", 7'h02, 1'b1, 8'hA5);
    frame_chk("R5 new value read", 7'h02, 1'b0, 8'h00);
    frame_chk("R5 read-only no change", 7'h02, 1'b0, 8'h3C);

    // R3 read-and-clear
    frame_chk("R3 read-clear returns", 7'h41, 1'b1, 8'h00);
    frame_chk("R3 cleared", 7'h41, 1'b0, 8'h00);

    // R4 event during frame survives the clear
    pulse_evt(64'h01 << 8);
    xfer({8'h00, 1'b1, 7'h42}, 16, 64'h02 << 8, r);
    check("R4 mid-frame clear response", r, {8'h01, summ()});
    stat_m[1] = 8'h02;
    frame_chk("R4 mid-frame event kept", 7'h42, 1'b0, 8'h00);

    // R7 wake level
    wk = 8'h5A;
    frame_chk("R7 wake level read", 7'h48, 1'b1, 8'h00);
    wk = 8'hC3;
    frame_chk("R7 wake level live", 7'h48, 1'b0, 8'h00);

    // R8 blocked mode
    blocked = 1'b1;
    frame_chk("R8 blocked write", 7'h03, 1'b1, 8'h77);
    frame_chk("R8 blocked clear", 7'h42, 1'b1, 8'h00);
    xfer(16'h0041, 10, '0, r);
    blocked = 1'b0;
    frame_chk("R8 ctrl unchanged", 7'h03, 1'b0, 8'h00);
    frame_chk("R8 no fail flag", 7'h43, 1'b0, 8'h00);

    // R9 short and long frames
    xfer({8'h99, 1'b1, 7'h01}, 12, '0, r);
    stat_m[2][0] = 1'b1;
    frame_chk("R9 short frame flag", 7'h43, 1'b1, 8'h00);
    frame_chk("R9 ctrl not written", 7'h01, 1'b0, 8'h00);
    xfer({8'h66, 1'b1, 7'h01}, 17, '0, r);
    stat_m[2][0] = 1'b1;
    frame_chk("R9 long frame flag", 7'h43, 1'b0, 8'h00);
    frame_chk("R9 long not written", 7'h01, 1'b0, 8'h00);

    // R10 unimplemented address
    frame_chk("R10 unimpl write", 7'h10, 1'b1, 8'hEE);
    frame_chk("R10 unimpl read", 7'h10, 1'b0, 8'h00);

    // R2 random traffic
    for (int it = 0; it < 160; it++) begin
      logic [6:0] a;
      int sel;
      if ($urandom % 3 == 0) pulse_evt({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      wk = 8'($urandom);
      blocked = ($urandom % 8 == 0);
      sel = $urandom % 4;
      case (sel)
        0: a = ($urandom % 8 == 7) ? 7'h4C : 7'(8'h41 + $urandom % 7);
        1: a = 7'(1 + $urandom % 4);
        2: a = 7'h48;
        default: begin
          a = 7'($urandom);
          if (stat_ix(a) >= 0 || ctrl_ix(a) >= 0 || a == 7'h48) a = 7'h20;
        end
      endcase
      if ($urandom % 16 == 0) begin
        xfer({8'($urandom), 1'b1, a}, 8 + $urandom % 6, '0, r);
        if (!blocked) stat_m[2][0] = 1'b1;
      end else begin
        frame_chk("R2 random frame", a, 1'($urandom), 8'($urandom));
      end
      blocked = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule